// File: doc/BRIEF.md
# Network-side line activation sequencer

This block sequences bring-up and shut-down of a two-wire digital subscriber line transceiver that sits at the network-termination end. It takes decoded commands from the control/indication (C/I) channel, single bits recovered from the line (the remote activation flag and the downstream-activation request), a superframe-detect strobe, a loop-back select, three training-done strobes and a three-bit test-mode code. From these it drives four outputs. The first is a four-bit indication code returned on the C/I channel. The second is a three-bit selector that tells the line transmitter which signal to send. The third and fourth are single-cycle pulses that reset the receiver and the controller's own software state.

Three features shape the sequencing. Shut-down ends with a confirmation code repeated on a fixed number of C/I frames. The receiver reset is issued only when the hold state is entered from somewhere other than the pending-shut-down state. A programmable hold-off timer in the hold state keeps a local activation command waiting, which gives the far end time to start activation first. Analog front end, equalizer, gain control, timing recovery and framing live elsewhere and appear here only as strobes.

Top module: `ntu_act_ctrl`

## Requirements
- R1: In the confirm-shutdown state, each `ci_strobe` loads indication code 4'hF. After the DC_REPEATS-th such strobe (default 4) the block enters the idle state, and the next strobe then returns code 4'h1.
- R2: `rx_rst` pulses high for one cycle when the hold state is entered from idle. It stays low when the hold state is entered from the pending-shutdown state.
- R3: An activation command (cmd 4'h8) in the hold state is acted on only once the hold-off has run out. With the command present, the selector reaches 3'd1 after exactly max(d+1, T7_TICKS+1) clock edges counted from the hold-state entry edge, where d is the cycle in which the command appears. A command 4'h8 in idle enters the hold state.
- R4: Reset command 4'h1 enters the reset state from any non-test state. `sw_rst` pulses for exactly one cycle on entry, the indication code there is 4'h0, and leaving the command moves the block to idle.
- R5: In the first synchronized state (selector 3'd2, code 4'h8), `line_uoa`=1 moves the block to the second synchronized state (code 4'h9). `line_uoa`=0 there moves it back.
- R6: In the second synchronized state, command 4'hC moves the block to the wait-for-remote-activation state (code 4'hA, selector 3'd2). `line_act`=1 there enters the transparent state (code 4'hC, selector 3'd3).
- R7: With `aloop_sel`=0, leaving hold enters the wait-for-superframe state. That state sends selector 3'd1 until `sf_det`, which moves the block to the first synchronized state.
- R8: With `aloop_sel`=1, leaving hold enters the loop-back training state (selector 3'd1). It moves to the first synchronized state on the edge on which all three of `agc_done`, `phase_done` and `eq_done` have been seen, whatever their order. Repeats of a strobe count once.
- R9: `tm`=3'b101 enters the test state (selector 3'd5, code 4'h6), ahead of every other transition including the reset command. Any other `tm` code has no effect, except that it ends the test state, which goes to reset.
- R10: `ind_code` changes only on a clock edge with `ci_strobe`=1. It then holds the code of the state the block was in at that edge.
- R11: Synchronous reset `rst` puts the block in the reset state with `ind_code`=4'h0, selector 3'd0 and both pulses low.
- R12: Command 4'hF in any state from wait-for-superframe through transparent enters pending-shutdown (code 4'h3, selector 3'd0). The next `ci_strobe` moves it to hold and restarts the hold-off. In hold, command 4'hF enters the confirm-shutdown state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ci_strobe | input | 1 | One cycle per C/I frame |
| cmd | input | 4 | Decoded C/I command |
| line_act | input | 1 | Remote activation flag from the line |
| line_uoa | input | 1 | Downstream activation request from the line |
| sf_det | input | 1 | Superframe detected strobe |
| aloop_sel | input | 1 | Analog loop-back selected |
| agc_done | input | 1 | Gain update done strobe |
| phase_done | input | 1 | Timing phase recovered strobe |
| eq_done | input | 1 | Equalizer update done strobe |
| tm | input | 3 | Test-mode code |
| ind_code | output | 4 | C/I indication code |
| line_sig | output | 3 | Transmit signal selector |
| rx_rst | output | 1 | Receiver reset pulse |
| sw_rst | output | 1 | Software reset pulse |

## Verification
The properties assume that `rst` is held for at least one edge before any stimulus, and that `T7_TICKS` and `DC_REPEATS` are at least one. The stimulus keeps to this by starting with three reset cycles and by using a hold-off of five ticks with the default repeat count. Inputs change only just after a clock edge and are sampled before the next one, so every transition occurs on a known edge. Commands and line bits are held until the expected edge and are then returned to neutral values. This keeps stray inputs from causing a transition while the bench is counting cycles.

// File: rtl/ntu_pkg.sv
package ntu_pkg;

  typedef enum logic [3:0] {
    S_RESET,
    S_IDLE,
    S_HOLD,
    S_SF_WAIT,
    S_SF_LOOP,
    S_SYNC_A,
    S_SYNC_B,
    S_ACT_WAIT,
    S_TRANSP,
    S_DEACT_PEND,
    S_DC_SEND,
    S_TEST
  } seq_state_e;

  localparam int CMD_W = 4;
  localparam int IND_W = 4;
  localparam int SIG_W = 3;

  localparam logic [CMD_W-1:0] CMD_RES = 4'h1;
  localparam logic [CMD_W-1:0] CMD_AR  = 4'h8;
  localparam logic [CMD_W-1:0] CMD_AI  = 4'hC;
  localparam logic [CMD_W-1:0] CMD_DI  = 4'hF;

  localparam logic [IND_W-1:0] IND_RST   = 4'h0;
  localparam logic [IND_W-1:0] IND_IDLE  = 4'h1;
  localparam logic [IND_W-1:0] IND_HOLD  = 4'h2;
  localparam logic [IND_W-1:0] IND_PEND  = 4'h3;
  localparam logic [IND_W-1:0] IND_TRAIN = 4'h4;
  localparam logic [IND_W-1:0] IND_TEST  = 4'h6;
  localparam logic [IND_W-1:0] IND_SYNCA = 4'h8;
  localparam logic [IND_W-1:0] IND_SYNCB = 4'h9;
  localparam logic [IND_W-1:0] IND_WACT  = 4'hA;
  localparam logic [IND_W-1:0] IND_LIVE  = 4'hC;
  localparam logic [IND_W-1:0] IND_DC    = 4'hF;

  localparam logic [SIG_W-1:0] SIG_SILENT = 3'd0;
  localparam logic [SIG_W-1:0] SIG_SN2    = 3'd1;
  localparam logic [SIG_W-1:0] SIG_SN3    = 3'd2;
  localparam logic [SIG_W-1:0] SIG_SN3T   = 3'd3;
  localparam logic [SIG_W-1:0] SIG_SSP    = 3'd5;

  localparam logic [2:0] TM_SSP = 3'b101;

  function automatic logic [IND_W-1:0] ind_of(input seq_state_e s);
    logic [IND_W-1:0] c;
    case (s)
      S_RESET:      c = IND_RST;
      S_IDLE:       c = IND_IDLE;
      S_HOLD:       c = IND_HOLD;
      S_SF_WAIT,
      S_SF_LOOP:    c = IND_TRAIN;
      S_SYNC_A:     c = IND_SYNCA;
      S_SYNC_B:     c = IND_SYNCB;
      S_ACT_WAIT:   c = IND_WACT;
      S_TRANSP:     c = IND_LIVE;
      S_DEACT_PEND: c = IND_PEND;
      S_DC_SEND:    c = IND_DC;
      S_TEST:       c = IND_TEST;
      default:      c = IND_RST;
    endcase
    return c;
  endfunction

  function automatic logic [SIG_W-1:0] sig_of(input seq_state_e s);
    logic [SIG_W-1:0] g;
    case (s)
      S_SF_WAIT,
      S_SF_LOOP:   g = SIG_SN2;
      S_SYNC_A,
      S_SYNC_B,
      S_ACT_WAIT:  g = SIG_SN3;
      S_TRANSP:    g = SIG_SN3T;
      S_TEST:      g = SIG_SSP;
      default:     g = SIG_SILENT;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/ntu_holdoff.sv
module ntu_holdoff #(
  parameter int T7_TICKS = 4000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int CW = $clog2(T7_TICKS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CW'(T7_TICKS);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

  // a fresh load always opens a non-empty hold-off window
  p_load_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> !expired);

endmodule

// File: rtl/ntu_ci_out.sv
module ntu_ci_out
  import ntu_pkg::*;
#(
  parameter int DC_REPEATS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ci_strobe,
  input  seq_state_e        state_q,
  output logic [IND_W-1:0]  ind_code,
  output logic              dc_done
);
  localparam int RW = $clog2(DC_REPEATS + 1);

  logic [RW-1:0] rep_cnt;
  logic          in_dc;

  assign in_dc   = (state_q == S_DC_SEND);
  assign dc_done = ci_strobe && in_dc && (rep_cnt == RW'(DC_REPEATS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      rep_cnt <= '0;
    end else if (!in_dc) begin
      rep_cnt <= '0;
    end else if (ci_strobe) begin
      rep_cnt <= rep_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ind_code <= IND_RST;
    end else if (ci_strobe) begin
      ind_code <= ind_of(state_q);
    end
  end

  // R10: the indication only moves on a frame strobe
  p_ind_stable_r10: assert property (@(posedge clk) disable iff (rst)
    !ci_strobe |=> $stable(ind_code));

  // R1: the repeat count never runs past the configured number
  p_dc_bound_r1: assert property (@(posedge clk) disable iff (rst)
    in_dc |-> (int'(rep_cnt) < DC_REPEATS));

endmodule

// File: rtl/ntu_seq_fsm.sv
module ntu_seq_fsm
  import ntu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ci_strobe,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              line_act,
  input  logic              line_uoa,
  input  logic              sf_det,
  input  logic              aloop_sel,
  input  logic              agc_done,
  input  logic              phase_done,
  input  logic              eq_done,
  input  logic [2:0]        tm,
  input  logic              t7_expired,
  input  logic              dc_done,
  output seq_state_e        state_q,
  output logic              t7_load,
  output logic [SIG_W-1:0]  line_sig,
  output logic              rx_rst,
  output logic              sw_rst
);
  seq_state_e nxt;
  logic agc_seen, phase_seen, eq_seen;
  logic train_all;
  logic is_active;

  assign train_all = (agc_seen | agc_done) & (phase_seen | phase_done) & (eq_seen | eq_done);

  assign is_active = (state_q == S_SF_WAIT) || (state_q == S_SF_LOOP) ||
                     (state_q == S_SYNC_A)  || (state_q == S_SYNC_B)  ||
                     (state_q == S_ACT_WAIT) || (state_q == S_TRANSP);

  // sticky record of the loop-back training strobes
  always_ff @(posedge clk) begin
    if (rst || state_q != S_SF_LOOP) begin
      agc_seen   <= 1'b0;
      phase_seen <= 1'b0;
      eq_seen    <= 1'b0;
    end else begin
      agc_seen   <= agc_seen   | agc_done;
      phase_seen <= phase_seen | phase_done;
      eq_seen    <= eq_seen    | eq_done;
    end
  end

  always_comb begin
    nxt = state_q;
    if (tm == TM_SSP) begin
      nxt = S_TEST;
    end else if (state_q == S_TEST) begin
      nxt = S_RESET;
    end else if (cmd == CMD_RES) begin
      nxt = S_RESET;
    end else if (is_active && cmd == CMD_DI) begin
      nxt = S_DEACT_PEND;
    end else begin
      case (state_q)
        S_RESET:      nxt = S_IDLE;
        S_IDLE:       if (cmd == CMD_AR) nxt = S_HOLD;
        S_HOLD: begin
          if (cmd == CMD_DI)
            nxt = S_DC_SEND;
          else if (cmd == CMD_AR && t7_expired)
            nxt = aloop_sel ? S_SF_LOOP : S_SF_WAIT;
        end
        S_SF_WAIT:    if (sf_det) nxt = S_SYNC_A;
        S_SF_LOOP:    if (train_all) nxt = S_SYNC_A;
        S_SYNC_A:     if (line_uoa) nxt = S_SYNC_B;
        S_SYNC_B: begin
          if (cmd == CMD_AI)
            nxt = S_ACT_WAIT;
          else if (!line_uoa)
            nxt = S_SYNC_A;
        end
        S_ACT_WAIT:   if (line_act) nxt = S_TRANSP;
        S_TRANSP:     nxt = S_TRANSP;
        S_DEACT_PEND: if (ci_strobe) nxt = S_HOLD;
        S_DC_SEND:    if (dc_done) nxt = S_IDLE;
        default:      nxt = S_RESET;
      endcase
    end
  end

  assign t7_load = (nxt == S_HOLD) && (state_q != S_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_RESET;
      line_sig <= SIG_SILENT;
      rx_rst   <= 1'b0;
      sw_rst   <= 1'b0;
    end else begin
      state_q  <= nxt;
      line_sig <= sig_of(nxt);
      rx_rst   <= t7_load && (state_q != S_DEACT_PEND);
      sw_rst   <= (nxt == S_RESET) && (state_q != S_RESET);
    end
  end

  // R2: leaving pending-shutdown never resets the receiver
  p_no_rxrst_pend_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DEACT_PEND) |=> !rx_rst);

  // R3: no start of training while the hold-off is still running
  p_holdoff_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_HOLD && !t7_expired) |=> (state_q != S_SF_WAIT && state_q != S_SF_LOOP));

  // R4: the software reset is a single-cycle pulse
  p_sw_single_r4: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> !sw_rst);

  // R7: superframe wait only ends on detection or an override
  p_sf_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_SF_WAIT && !sf_det) |=> (state_q != S_SYNC_A));

  // R8: loop-back training needs all three strobes
  p_loop_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_SF_LOOP && !train_all) |=> (state_q != S_SYNC_A));

  // R9: the test code wins over everything
  p_test_entry_r9: assert property (@(posedge clk) disable iff (rst)
    (tm == TM_SSP) |=> (state_q == S_TEST && line_sig == SIG_SSP));

  // R1: confirm-shutdown stays put until the repeat count is met
  p_dc_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DC_SEND && !dc_done && tm != TM_SSP && cmd != CMD_RES) |=> (state_q == S_DC_SEND));

endmodule

// File: rtl/ntu_act_ctrl.sv
module ntu_act_ctrl
  import ntu_pkg::*;
#(
  parameter int T7_TICKS   = 4000,
  parameter int DC_REPEATS = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ci_strobe,
  input  logic [3:0]  cmd,
  input  logic        line_act,
  input  logic        line_uoa,
  input  logic        sf_det,
  input  logic        aloop_sel,
  input  logic        agc_done,
  input  logic        phase_done,
  input  logic        eq_done,
  input  logic [2:0]  tm,
  output logic [3:0]  ind_code,
  output logic [2:0]  line_sig,
  output logic        rx_rst,
  output logic        sw_rst
);
  seq_state_e state_q;
  logic       t7_load;
  logic       t7_expired;
  logic       dc_done;

  ntu_holdoff #(.T7_TICKS(T7_TICKS)) u_holdoff (
    .clk     (clk),
    .rst     (rst),
    .load    (t7_load),
    .expired (t7_expired)
  );

  ntu_ci_out #(.DC_REPEATS(DC_REPEATS)) u_ci_out (
    .clk       (clk),
    .rst       (rst),
    .ci_strobe (ci_strobe),
    .state_q   (state_q),
    .ind_code  (ind_code),
    .dc_done   (dc_done)
  );

  ntu_seq_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .ci_strobe  (ci_strobe),
    .cmd        (cmd),
    .line_act   (line_act),
    .line_uoa   (line_uoa),
    .sf_det     (sf_det),
    .aloop_sel  (aloop_sel),
    .agc_done   (agc_done),
    .phase_done (phase_done),
    .eq_done    (eq_done),
    .tm         (tm),
    .t7_expired (t7_expired),
    .dc_done    (dc_done),
    .state_q    (state_q),
    .t7_load    (t7_load),
    .line_sig   (line_sig),
    .rx_rst     (rx_rst),
    .sw_rst     (sw_rst)
  );

endmodule

// File: tb/ntu_act_ctrl_test.sv
`timescale 1ns/100ps
module ntu_act_ctrl_test;
  localparam int T7  = 5;
  localparam int REP = 4;
  localparam int WD_LIMIT = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ci_strobe = 1'b0;
  logic [3:0] cmd = 4'h0;
  logic       line_act = 1'b0, line_uoa = 1'b0, sf_det = 1'b0, aloop_sel = 1'b0;
  logic       agc_done = 1'b0, phase_done = 1'b0, eq_done = 1'b0;
  logic [2:0] tm = 3'b000;
  logic [3:0] ind_code;
  logic [2:0] line_sig;
  logic       rx_rst, sw_rst;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ntu_act_ctrl #(.T7_TICKS(T7), .DC_REPEATS(REP)) uut (
    .clk(clk), .rst(rst), .ci_strobe(ci_strobe), .cmd(cmd),
    .line_act(line_act), .line_uoa(line_uoa), .sf_det(sf_det),
    .aloop_sel(aloop_sel), .agc_done(agc_done), .phase_done(phase_done),
    .eq_done(eq_done), .tm(tm), .ind_code(ind_code), .line_sig(line_sig),
    .rx_rst(rx_rst), .sw_rst(sw_rst)
  );

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    wait (cyc > WD_LIMIT);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got %0d cycles expected under %0d", cyc, WD_LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic strobe_once();
    ci_strobe = 1'b1;
    step(1);
    ci_strobe = 1'b0;
  endtask

  // from idle: enter hold with a command, re-apply it after d cycles,
  // count edges from the entry edge until training starts
  task automatic hold_and_count(input int d, input logic loop, output int n);
    aloop_sel = loop;
    cmd = 4'h8;
    step(1);
    n = 0;
    cmd = 4'h0;
    repeat (d) begin step(1); n++; end
    cmd = 4'h8;
    while (line_sig != 3'd1 && n < 40) begin step(1); n++; end
    cmd = 4'h0;
  endtask

  // from any active state back to idle through the full shutdown path
  task automatic go_idle();
    cmd = 4'hF; step(1);
    cmd = 4'h0; strobe_once();
    cmd = 4'hF; step(1);
    cmd = 4'h0;
    repeat (REP) strobe_once();
  endtask

  initial begin
    int n;
    int order [3];
    step(3);
    rst = 1'b0;
    // R11: reset state
    check("R11 ind", ind_code, 0);
    check("R11 sig", line_sig, 0);
    check("R11 rx", rx_rst, 0);
    check("R11 sw", sw_rst, 0);
    step(1);
    strobe_once();
    check("R4 idle after reset", ind_code, 1);

    // R2 / R3 / R10: activation from idle
    cmd = 4'h8;
    step(1);
    check("R2 rx pulse", rx_rst, 1);
    n = 0;
    step(1); n++;
    check("R2 rx single", rx_rst, 0);
    while (line_sig != 3'd1 && n < 40) begin
      step(1); n++;
      if (line_sig != 3'd1) check("R10 ind held", ind_code, 1);
    end
    cmd = 4'h0;
    check("R3 holdoff edges", n, T7 + 1);

    // R7: superframe wait
    step(3);
    check("R7 sn2 held", line_sig, 1);
    sf_det = 1'b1; step(1); sf_det = 1'b0;
    check("R7 sync", line_sig, 2);

    // R5
    strobe_once();
    check("R5 sync a", ind_code, 8);
    line_uoa = 1'b1; step(1);
    strobe_once();
    check("R5 sync b", ind_code, 9);
    line_uoa = 1'b0; step(1);
    strobe_once();
    check("R5 back", ind_code, 8);
    line_uoa = 1'b1; step(1);

    // R6
    cmd = 4'hC; step(1); cmd = 4'h0;
    strobe_once();
    check("R6 wait act", ind_code, 10);
    check("R6 sig", line_sig, 2);
    line_act = 1'b1; step(1); line_act = 1'b0;
    check("R6 transparent sig", line_sig, 3);
    strobe_once();
    check("R6 transparent ind", ind_code, 12);
    line_uoa = 1'b0;

    // R12 / R2 exception
    cmd = 4'hF; step(1); cmd = 4'h0;
    check("R12 pend sig", line_sig, 0);
    step(3);
    strobe_once();
    check("R12 pend ind", ind_code, 3);
    check("R2 no rx from pend", rx_rst, 0);
    cmd = 4'h8;
    n = 0;
    step(1); n++;
    check("R2 no rx later", rx_rst, 0);
    while (line_sig != 3'd1 && n < 40) begin step(1); n++; end
    cmd = 4'h0;
    check("R12 holdoff restarted", n, T7 + 1);

    // R1: confirm code repeated
    cmd = 4'hF; step(1);
    cmd = 4'h0; strobe_once();
    cmd = 4'hF; step(1);
    cmd = 4'h0;
    check("R1 silent", line_sig, 0);
    for (int i = 0; i < REP; i++) begin
      step(3);
      strobe_once();
      check("R1 dc", ind_code, 15);
    end
    step(2);
    strobe_once();
    check("R1 idle after repeats", ind_code, 1);

    // R4: reset command
    cmd = 4'h1; step(1);
    check("R4 sw pulse", sw_rst, 1);
    step(1);
    check("R4 sw single", sw_rst, 0);
    strobe_once();
    check("R4 code", ind_code, 0);
    cmd = 4'h0; step(1);
    strobe_once();
    check("R4 to idle", ind_code, 1);

    // R3 sweep over command arrival offsets
    for (int d = 0; d <= T7 + 3; d++) begin
      hold_and_count(d, 1'b0, n);
      check("R3 offset", n, (d + 1 > T7 + 1) ? d + 1 : T7 + 1);
      go_idle();
    end

    // R8: every order of the three training strobes
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++) begin
          if (a != b && b != c && a != c) begin
            order[0] = a; order[1] = b; order[2] = c;
            hold_and_count(0, 1'b1, n);
            check("R8 entry", n, T7 + 1);
            for (int k = 0; k < 3; k++) begin
              agc_done   = (order[k] == 0);
              phase_done = (order[k] == 1);
              eq_done    = (order[k] == 2);
              step(1);
              agc_done = 1'b0; phase_done = 1'b0; eq_done = 1'b0;
              if (k < 2) begin
                check("R8 waiting", line_sig, 1);
                step(2);
                if (k == 0) begin
                  // repeat of the same strobe counts once
                  agc_done   = (order[0] == 0);
                  phase_done = (order[0] == 1);
                  eq_done    = (order[0] == 2);
                  step(1);
                  agc_done = 1'b0; phase_done = 1'b0; eq_done = 1'b0;
                  check("R8 repeat", line_sig, 1);
                end
              end
            end
            check("R8 synced", line_sig, 2);
            go_idle();
          end
        end
    aloop_sel = 1'b0;

    // R9: test mode
    hold_and_count(0, 1'b0, n);
    sf_det = 1'b1; step(1); sf_det = 1'b0;
    tm = 3'b100; step(2);
    check("R9 other code ignored", line_sig, 2);
    tm = 3'b101; cmd = 4'h1; step(1);
    check("R9 ssp", line_sig, 5);
    check("R9 beats reset", sw_rst, 0);
    strobe_once();
    check("R9 code", ind_code, 6);
    tm = 3'b000; cmd = 4'h0; step(1);
    check("R9 exit sig", line_sig, 0);
    check("R9 exit reset", sw_rst, 1);
    step(1);
    strobe_once();
    check("R9 idle", ind_code, 1);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule